// File: doc/BRIEF.md
# SDRAM Clock-Enable Power State Controller

This block tracks the power state of a synchronous DRAM device from the clock-enable input and the command strobes. On every rising clock edge it compares the clock-enable level at this edge with the level at the previous edge. That pair, the command on chip select and the three strobes, and an all-banks-idle indication from a separate bank tracker decide the next state. The states are all-banks-idle, active, power-down, self-refresh, self-refresh exit and clock suspend.

The block reports its state as a 3-bit code. It raises a one-cycle flag when the host drives a combination that is illegal or invalid for the current state. It also drives a gated clock enable that holds internal burst logic frozen whenever the device clock is logically stopped.

Leaving self-refresh passes through an exit state. That state lasts a programmable number of cycles, the row-cycle time, before the device is idle again. While the device is in self-refresh, an internal interval timer pulses a refresh request once per `REF_PERIOD` cycles. The default period is 780 cycles, which is 64 ms divided by 8192 at a 100 MHz clock.

Top module: `sdram_cke_fsm`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `state` is 0 (idle), `illegal` is 0, `int_cke` is 1 and `ref_tick` is 0. The clock-enable value remembered from the previous edge resets to high.
- R2: When clock enable is high at both the previous and the current edge, `state` becomes 0 (idle) if `banks_idle` is high and 1 (active) if it is low. The new state is visible after that edge.
- R3: Commands are `{cs_n,ras_n,cas_n,we_n}`: deselect is `1xxx`, no-operation is `0111`, auto-refresh is `0001`. With `banks_idle` high and clock enable falling (high, then low), auto-refresh moves to self-refresh (code 3) and deselect or no-operation moves to power-down (code 2). Any other command raises `illegal` for one cycle and stays idle.
- R4: With `banks_idle` low, clock enable falling moves to clock suspend (code 5) for every command, auto-refresh included, so self-refresh is never entered.
- R5: In power-down, clock enable low at both edges keeps power-down. Clock enable rising returns to idle. The rise also raises `illegal` when the command is not deselect or no-operation.
- R6: In self-refresh, clock enable low at both edges keeps self-refresh. A rise with deselect or no-operation moves to self-refresh exit (code 4). A rise with any other command raises `illegal` and stays in self-refresh. While in self-refresh or power-down, a previous-edge clock enable that was high raises `illegal`.
- R7: Self-refresh exit lasts exactly `max(exit_cycles,1)` cycles and then becomes idle. Clock enable, commands and `banks_idle` have no effect during it, and it never raises `illegal`.
- R8: Clock enable falling in active moves to clock suspend at the next cycle. Clock enable low at both edges keeps suspend. A rise leaves suspend for active or idle by `banks_idle`. `int_cke` is low in suspend, power-down, self-refresh and self-refresh exit, and high in idle and active.
- R9: `ref_tick` is high only in self-refresh. It pulses on the `REF_PERIOD`-th cycle spent there and on every `REF_PERIOD` cycles after that, so a stay of S cycles gives floor(S/`REF_PERIOD`) pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable sampled at each edge |
| cs_n | input | 1 | Chip select, low selects |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| banks_idle | input | 1 | High when the bank tracker sees all banks precharged |
| exit_cycles | input | CNT_W | Self-refresh exit length in cycles (0 treated as 1) |
| state | output | 3 | Power state code: 0 idle, 1 active, 2 power-down, 3 self-refresh, 4 exit, 5 suspend |
| illegal | output | 1 | One-cycle flag for an illegal or invalid input combination |
| int_cke | output | 1 | Gated clock enable for internal burst logic |
| ref_tick | output | 1 | Refresh request pulse while in self-refresh |

## Verification
A wrong state shows on the `state` port on the cycle after the edge that caused it. The same edge also moves `int_cke` the wrong way, which would freeze or release burst logic early. A stale remembered clock-enable value shows up as a missed or spurious transition, or as a stray `illegal` pulse, on the very next edge. An off-by-one in the exit counter or the refresh interval changes the count of exit cycles or of `ref_tick` pulses. The sweeps measure those counts directly over several lengths.

// File: rtl/sdram_cke_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock-enable power state controller.
// Assumes a single-rank device with one clock-enable input.
package sdram_cke_pkg;

    // Power state codes; the numeric values are visible on the top-level port.
    typedef enum logic [2:0] {
        PS_IDLE      = 3'd0,
        PS_ACTIVE    = 3'd1,
        PS_PDOWN     = 3'd2,
        PS_SREF      = 3'd3,
        PS_SREF_EXIT = 3'd4,
        PS_SUSPEND   = 3'd5
    } pwr_state_t;

    // Command classes that matter for clock-enable transitions.
    typedef struct packed {
        logic quiet;    // deselect or no-operation
        logic refresh;  // auto-refresh encoding
    } cmd_class_t;

endpackage

// File: rtl/cke_cmd_classify.sv
`timescale 1ns/1ps
// Classifies the command strobes into the classes used by the power FSM.
// Assumes strobes are already synchronous to clk; purely combinational.
module cke_cmd_classify
    import sdram_cke_pkg::*;
(
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    output cmd_class_t cls
);

    // Decode deselect / no-op and auto-refresh from the strobe pattern.
    always_comb begin
        cls.quiet   = cs_n | (ras_n & cas_n & we_n);
        cls.refresh = ~cs_n & ~ras_n & ~cas_n & we_n;
    end

endmodule

// File: rtl/cke_exit_timer.sv
`timescale 1ns/1ps
// Down-counter that times the self-refresh exit phase.
// Loaded when the exit is accepted; reports done on the last exit cycle.
// Assumes a load value of zero means one cycle.
module cke_exit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;

    // Load the exit length, then count down while the exit phase runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= (load_val == '0) ? ONE : load_val;
        end else if (run && remain != '0) begin
            remain <= remain - ONE;
        end
    end

    // Last exit cycle when one (or, defensively, zero) cycle remains.
    always_comb begin
        done = (remain <= ONE);
    end

endmodule

// File: rtl/cke_refresh_timer.sv
`timescale 1ns/1ps
// Interval timer that requests an internal refresh while in self-refresh.
// Counts cycles spent in self-refresh and pulses once per REF_PERIOD cycles.
// Assumes REF_PERIOD >= 2.
module cke_refresh_timer #(
    parameter int REF_PERIOD = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_sref,
    output logic tick
);

    localparam int RW = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1;
    localparam logic [RW-1:0] LAST = RW'(REF_PERIOD - 1);

    logic [RW-1:0] phase;

    // Phase counter: cleared outside self-refresh, wraps at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!in_sref || phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + RW'(1);
        end
    end

    // Pulse on the final cycle of each period while still in self-refresh.
    always_comb begin
        tick = in_sref && (phase == LAST);
    end

endmodule

// File: rtl/cke_state_core.sv
`timescale 1ns/1ps
// Power state register and next-state decision for the clock-enable FSM.
// Decides from the clock-enable pair (previous edge, current edge), the
// command class and the bank-idle indication. Illegal is registered.
module cke_state_core
    import sdram_cke_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  cmd_class_t cls,
    input  logic       banks_idle,
    input  logic       exit_done,
    output pwr_state_t cur,
    output logic       illegal,
    output logic       exit_load
);

    logic       cke_prev;
    pwr_state_t nxt;
    logic       ill_nxt;
    logic       rise;
    logic       fall;

    // Edge classification of the clock-enable pair.
    always_comb begin
        rise = ~cke_prev & cke;
        fall = cke_prev & ~cke;
    end

    // Next-state and illegal-combination decision.
    always_comb begin
        nxt       = cur;
        ill_nxt   = 1'b0;
        exit_load = 1'b0;
        unique case (cur)
            PS_IDLE, PS_ACTIVE: begin
                if (fall) begin
                    if (banks_idle) begin
                        if (cls.refresh) begin
                            nxt = PS_SREF;
                        end else if (cls.quiet) begin
                            nxt = PS_PDOWN;
                        end else begin
                            nxt     = PS_IDLE;
                            ill_nxt = 1'b1;
                        end
                    end else begin
                        nxt = PS_SUSPEND;
                    end
                end else begin
                    nxt = banks_idle ? PS_IDLE : PS_ACTIVE;
                end
            end
            PS_SUSPEND: begin
                if (rise) begin
                    nxt = banks_idle ? PS_IDLE : PS_ACTIVE;
                end
            end
            PS_PDOWN: begin
                if (cke_prev) begin
                    ill_nxt = 1'b1;
                end else if (cke) begin
                    nxt     = PS_IDLE;
                    ill_nxt = ~cls.quiet;
                end
            end
            PS_SREF: begin
                if (cke_prev) begin
                    ill_nxt = 1'b1;
                end else if (cke) begin
                    if (cls.quiet) begin
                        nxt       = PS_SREF_EXIT;
                        exit_load = 1'b1;
                    end else begin
                        ill_nxt = 1'b1;
                    end
                end
            end
            PS_SREF_EXIT: begin
                if (exit_done) begin
                    nxt = PS_IDLE;
                end
            end
            default: begin
                nxt = PS_IDLE;
            end
        endcase
    end

    // State, remembered clock enable and illegal flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= PS_IDLE;
            cke_prev <= 1'b1;
            illegal  <= 1'b0;
        end else begin
            cur      <= nxt;
            cke_prev <= cke;
            illegal  <= ill_nxt;
        end
    end

endmodule

// File: rtl/sdram_cke_fsm.sv
`timescale 1ns/1ps
// Top of the SDRAM clock-enable power state controller.
// Combines command classification, the state core, the self-refresh exit
// timer and the self-refresh interval timer, and gates the internal clock
// enable. Assumes all inputs are synchronous to clk.
module sdram_cke_fsm
    import sdram_cke_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int REF_PERIOD = 780
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             banks_idle,
    input  logic [CNT_W-1:0] exit_cycles,
    output logic [2:0]       state,
    output logic             illegal,
    output logic             int_cke,
    output logic             ref_tick
);

    cmd_class_t cls;
    pwr_state_t cur;
    logic       exit_load;
    logic       exit_done;
    logic       in_sref;
    logic       in_exit;

    cke_cmd_classify i_classify (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cls   (cls)
    );

    cke_state_core i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cls        (cls),
        .banks_idle (banks_idle),
        .exit_done  (exit_done),
        .cur        (cur),
        .illegal    (illegal),
        .exit_load  (exit_load)
    );

    cke_exit_timer #(.CNT_W(CNT_W)) i_exit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (exit_load),
        .run      (in_exit),
        .load_val (exit_cycles),
        .done     (exit_done)
    );

    cke_refresh_timer #(.REF_PERIOD(REF_PERIOD)) i_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_sref (in_sref),
        .tick    (ref_tick)
    );

    // State decode for the timers and the gated internal clock enable.
    always_comb begin
        in_sref = (cur == PS_SREF);
        in_exit = (cur == PS_SREF_EXIT);
        int_cke = (cur == PS_IDLE) || (cur == PS_ACTIVE);
        state   = cur;
    end

endmodule

// File: rtl/sdram_cke_fsm_chk.sv
`timescale 1ns/1ps
// Assertion checker for sdram_cke_fsm, attached by bind below.
// Observes only the top-level ports.
module sdram_cke_fsm_chk
    import sdram_cke_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       banks_idle,
    input logic [2:0] state,
    input logic       illegal,
    input logic       int_cke,
    input logic       ref_tick
);

    // R4
    sref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_SREF && $past(state) != PS_SREF)
            |-> ($past(banks_idle) && !$past(cke)));

    // R7
    sref_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_SREF) |-> (state == PS_SREF || state == PS_SREF_EXIT));

    // R7
    exit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_SREF_EXIT) |-> !illegal);

    // R8
    suspend_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_ACTIVE && state == PS_SUSPEND) |-> !$past(cke));

    // R8
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_SUSPEND || state == PS_PDOWN) |-> !int_cke);

    // R9
    tick_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |-> (state == PS_SREF));

    // R9
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> !ref_tick);

    // R5
    pdown_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_PDOWN) |-> (state == PS_PDOWN || state == PS_IDLE));

endmodule

bind sdram_cke_fsm sdram_cke_fsm_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .banks_idle (banks_idle),
    .state      (state),
    .illegal    (illegal),
    .int_cke    (int_cke),
    .ref_tick   (ref_tick)
);

// File: tb/test_sdram_cke_fsm.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps commands and lengths over a small configuration.
module test_sdram_cke_fsm;

    localparam int CW    = 4;
    localparam int REF_P = 6;

    localparam logic [3:0] C_NOP   = 4'b0111;
    localparam logic [3:0] C_DESEL = 4'b1111;
    localparam logic [3:0] C_REF   = 4'b0001;
    localparam logic [3:0] C_ACT   = 4'b0011;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1;
    logic          cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic          banks_idle = 1'b1;
    logic [CW-1:0] exit_cycles = CW'(3);
    logic [2:0]    state;
    logic          illegal, int_cke, ref_tick;

    int checks = 0;
    int errors = 0;

    sdram_cke_fsm #(.CNT_W(CW), .REF_PERIOD(REF_P)) i_sdram_cke_fsm (
        .clk (clk), .rst_n (rst_n), .cke (cke),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .banks_idle (banks_idle), .exit_cycles (exit_cycles),
        .state (state), .illegal (illegal), .int_cke (int_cke), .ref_tick (ref_tick)
    );

    always #5 clk = ~clk;

    function automatic bit is_quiet(input logic [3:0] c);
        return c[3] || (c == C_NOP);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive inputs 1 ns after an edge, wait for the next edge, settle 1 ns.
    task automatic apply(input logic k, input logic [3:0] c, input logic idle);
        cke = k;
        {cs_n, ras_n, cas_n, we_n} = c;
        banks_idle = idle;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cke = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        banks_idle = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic enter_sref();
        do_reset();
        apply(1'b1, C_NOP, 1'b1);
        apply(1'b0, C_REF, 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        int ticks;
        do_reset();
        // R1 reset state
        chk("R1 state", state, 0);
        chk("R1 illegal", illegal, 0);
        chk("R1 int_cke", int_cke, 1);
        chk("R1 ref_tick", ref_tick, 0);

        // R2 idle / active tracking
        apply(1'b1, C_NOP, 1'b0);
        chk("R2 active", state, 1);
        apply(1'b1, C_NOP, 1'b1);
        chk("R2 idle", state, 0);

        // R3 sweep every command on a falling clock enable from idle
        for (int c = 0; c < 16; c++) begin
            do_reset();
            apply(1'b1, C_NOP, 1'b1);
            apply(1'b0, 4'(c), 1'b1);
            if (4'(c) == C_REF) begin
                chk("R3 sref", state, 3);
                chk("R3 sref ill", illegal, 0);
            end else if (is_quiet(4'(c))) begin
                chk("R3 pdown", state, 2);
                chk("R3 pdown ill", illegal, 0);
            end else begin
                chk("R3 stay", state, 0);
                chk("R3 ill", illegal, 1);
            end
        end

        // R4 / R8 busy banks: every command falls into clock suspend
        for (int c = 0; c < 16; c++) begin
            do_reset();
            apply(1'b1, C_NOP, 1'b0);
            apply(1'b0, 4'(c), 1'b0);
            chk("R4 suspend", state, 5);
            chk("R8 gate low", int_cke, 0);
            apply(1'b0, 4'(c), 1'b0);
            chk("R8 hold", state, 5);
            apply(1'b1, C_NOP, 1'b0);
            chk("R8 resume", state, 1);
            chk("R8 gate high", int_cke, 1);
        end

        // R5 power-down exit with every command
        for (int c = 0; c < 16; c++) begin
            do_reset();
            apply(1'b1, C_NOP, 1'b1);
            apply(1'b0, C_NOP, 1'b1);
            apply(1'b0, C_DESEL, 1'b1);
            chk("R5 hold", state, 2);
            chk("R8 pdown gate", int_cke, 0);
            apply(1'b1, 4'(c), 1'b1);
            chk("R5 exit", state, 0);
            chk("R5 ill", illegal, is_quiet(4'(c)) ? 0 : 1);
        end

        // R6 self-refresh exit attempt with every command
        exit_cycles = CW'(3);
        for (int c = 0; c < 16; c++) begin
            enter_sref();
            apply(1'b0, C_NOP, 1'b1);
            chk("R6 hold", state, 3);
            chk("R8 sref gate", int_cke, 0);
            apply(1'b1, 4'(c), 1'b1);
            if (is_quiet(4'(c))) begin
                chk("R6 exit", state, 4);
                chk("R6 exit ill", illegal, 0);
            end else begin
                chk("R6 reject", state, 3);
                chk("R6 reject ill", illegal, 1);
                apply(1'b0, C_NOP, 1'b1);
                chk("R6 invalid ill", illegal, 1);
                apply(1'b0, C_NOP, 1'b1);
                chk("R6 clear ill", illegal, 0);
                apply(1'b1, C_NOP, 1'b1);
                chk("R6 retry", state, 4);
            end
        end

        // R7 exit length sweep with noisy inputs during the exit
        for (int n = 0; n < 7; n++) begin
            exit_cycles = CW'(n);
            enter_sref();
            apply(1'b1, C_NOP, 1'b1);
            cnt = (state == 3'd4) ? 1 : 0;
            ticks = 0;
            for (int i = 0; i < 20; i++) begin
                apply(1'(i % 2), C_ACT, 1'(i % 3 == 0));
                if (illegal) ticks++;
                if (state != 3'd4) break;
                cnt++;
            end
            chk("R7 length", cnt, (n == 0) ? 1 : n);
            chk("R7 idle after", state, 0);
            chk("R7 no ill", ticks, 0);
        end

        // R9 refresh pulses over several stay lengths
        exit_cycles = CW'(2);
        for (int k = 0; k < 6; k++) begin
            int s;
            s = (k == 0) ? 1 : (k == 1) ? 5 : (k == 2) ? 6 : (k == 3) ? 7 : (k == 4) ? 13 : 19;
            enter_sref();
            ticks = ref_tick ? 1 : 0;
            for (int i = 1; i < s; i++) begin
                apply(1'b0, C_NOP, 1'b1);
                if (ref_tick) ticks++;
            end
            chk("R9 count", ticks, s / REF_P);
            apply(1'b1, C_NOP, 1'b1);
            cnt = ref_tick ? 1 : 0;
            apply(1'b1, C_NOP, 1'b1);
            if (ref_tick) cnt++;
            chk("R9 none in exit", cnt, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule